// File: doc/BRIEF.md
# Multi-Bank DRAM Command State Tracker

This block is a synchronous, cycle-accurate model of the command side of a multi-bank DRAM device. On every rising clock edge it samples the active-low chip select and the three command strobes, together with the clock-enable, the bank address and the row/column address. It turns them into one command and keeps a record, for each bank, of whether a row is open and which row it is. Command sequences that break the bank rules are flagged with a single-cycle error pulse, and the offending command leaves all state untouched.

Banks open and close on their own, so a row can be opened in one bank while another bank is being read or written. Refresh is only taken when every bank is closed. A refresh given with the clock-enable low puts the model in self-refresh, where strobes are disregarded until the clock-enable returns high. A mode-register load captures the burst length code, the burst ordering and the read latency for the rest of the system to read. Data movement is reported only as a read or write command tagged with its bank.

Top module: `dram_cmd_tracker`

## Requirements
- R1: Command code on `cmd_o` one cycle after sampling, with `cs_n` low and strobes `{ras_n,cas_n,we_n}`: 011 gives 1 (open row), 101 gives 2 (read), 100 gives 3 (write), 010 gives 4 (close), 001 gives 5 (refresh), 110 gives 6 (burst stop), 000 gives 7 (mode load), 111 gives 0 (no operation). With `cs_n` high the code is 0 whatever the strobes. Self-refresh entry reports 8 and exit reports 9. `cmd_bank_o` reports the sampled bank address.
- R2: An open-row command to a closed bank sets that bank's bit in `bank_open_o` and its 13-bit field of `open_row_o` (bank b at bits b*13 and up) to the sampled address. Other banks keep their state.
- R3: Read or write to an open bank raises no error and changes no bank state.
- R4: A close command with address bit 10 low closes only the addressed bank. With address bit 10 high it closes all banks. A closed bank reads row 0. Closing an already closed bank is not an error.
- R5: Read or write to a closed bank, or an open-row command to an open bank, sets `err_o` for that one result cycle and changes no bank state.
- R6: Refresh while any bank is open sets `err_o` and is ignored; in particular it never enters self-refresh. Refresh with all banks closed raises no error.
- R7: Refresh with all banks closed and `cke` low sets `sr_o` and reports code 8. While `sr_o` is high and `cke` is low, all commands are ignored and `cmd_o` shows 0. The first edge with `cke` high clears `sr_o` and reports code 9.
- R8: A mode load with bank address 0 captures address bits [2:0] into `burst_len_o`, bit 3 into `burst_ilv_o` and bits [6:4] into `cas_lat_o`. With any other bank address (extended register) these outputs keep their values.
- R9: After synchronous reset all banks are closed with row 0, `cmd_o` is 0, and `err_o`, `sr_o`, `cmd_bank_o` and the mode outputs are 0.
- R10: Burst stop and no-operation cause no error and no bank state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low with refresh enters self-refresh, high leaves it |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row address, close-all flag on bit 10, mode fields |
| cmd_o | output | 4 | Registered command code |
| cmd_bank_o | output | 2 | Registered bank address of the command |
| err_o | output | 1 | One-cycle illegal-sequence pulse |
| sr_o | output | 1 | Self-refresh mode |
| bank_open_o | output | 4 | Per-bank open flag |
| open_row_o | output | 52 | Per-bank open row, 13 bits each |
| burst_len_o | output | 3 | Captured burst length code |
| burst_ilv_o | output | 1 | Captured burst ordering (1 = interleaved) |
| cas_lat_o | output | 3 | Captured read latency |

## Verification
A bank flag or row register that goes wrong shows up at the ports one cycle after the edge that corrupted it, through `bank_open_o` and `open_row_o`. It also shows later as a false or missing `err_o` pulse on the next read, write, open or refresh to that bank. A self-refresh flag that is stuck or lost shows in `sr_o` at once, and on the next command as a wrong code (0, 8 or 9 against the decoded one). The bench runs every strobe pattern with chip select low and high. It then runs a scripted sequence that walks each bank through open, access, close and every illegal case. All outputs are compared after every edge against a model written from the requirements.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'd0,
    CMD_ACT = 4'd1,
    CMD_RD  = 4'd2,
    CMD_WR  = 4'd3,
    CMD_PRE = 4'd4,
    CMD_REF = 4'd5,
    CMD_BST = 4'd6,
    CMD_MRS = 4'd7,
    CMD_SRE = 4'd8,
    CMD_SRX = 4'd9
  } dct_cmd_e;
endpackage

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output dct_cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b110:  cmd = CMD_BST;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dct_bank.sv
module dct_bank #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_en) begin
      open_q <= 1'b1;
      row_q  <= row_in;
    end else if (close_en) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end
  end

  assert_open_latches_row_R2: assert property (@(posedge clk) disable iff (rst)
    open_en |=> (open_q && row_q == $past(row_in)));

  assert_close_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (close_en && !open_en) |=> (!open_q && row_q == '0));
endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmd_o,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank_o,
  output logic                       err_o,
  output logic                       sr_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic [2:0]                 burst_len_o,
  output logic                       burst_ilv_o,
  output logic [2:0]                 cas_lat_o
);
  localparam int BA_W = $clog2(NUM_BANKS);

  dct_cmd_e             dec;
  dct_cmd_e             cmd_d;
  logic [NUM_BANKS-1:0] bank_open;
  logic [NUM_BANKS-1:0] open_en;
  logic [NUM_BANKS-1:0] close_en;
  logic                 sr_q;
  logic                 live;
  logic                 any_open;
  logic                 cur_open;
  logic                 err_d;
  logic                 sr_enter;

  dct_decode u_decode (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (dec)
  );

  always_comb begin
    live     = !sr_q;
    any_open = |bank_open;
    cur_open = bank_open[ba];
    err_d    = live && ((((dec == CMD_RD) || (dec == CMD_WR)) && !cur_open) ||
                        ((dec == CMD_ACT) && cur_open) ||
                        ((dec == CMD_REF) && any_open));
    sr_enter = live && (dec == CMD_REF) && !any_open && !cke;
    if (sr_q)          cmd_d = cke ? CMD_SRX : CMD_NOP;
    else if (sr_enter) cmd_d = CMD_SRE;
    else               cmd_d = dec;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ROW_W-1:0] row_q;
    assign open_en[b]  = live && (dec == CMD_ACT) && (ba == BA_W'(b)) && !bank_open[b];
    assign close_en[b] = live && (dec == CMD_PRE) && (addr[AP_BIT] || (ba == BA_W'(b)));
    dct_bank #(.ROW_W(ROW_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .open_en (open_en[b]),
      .close_en(close_en[b]),
      .row_in  (addr),
      .open_q  (bank_open[b]),
      .row_q   (row_q)
    );
    assign open_row_o[b*ROW_W +: ROW_W] = row_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o       <= CMD_NOP;
      cmd_bank_o  <= '0;
      err_o       <= 1'b0;
      sr_q        <= 1'b0;
      burst_len_o <= '0;
      burst_ilv_o <= 1'b0;
      cas_lat_o   <= '0;
    end else begin
      cmd_o      <= cmd_d;
      cmd_bank_o <= ba;
      err_o      <= err_d;
      if (sr_enter)        sr_q <= 1'b1;
      else if (sr_q && cke) sr_q <= 1'b0;
      if (live && (dec == CMD_MRS) && (ba == '0)) begin
        burst_len_o <= addr[2:0];
        burst_ilv_o <= addr[3];
        cas_lat_o   <= addr[6:4];
      end
    end
  end

  assign sr_o        = sr_q;
  assign bank_open_o = bank_open;

  assert_sr_all_idle_R7: assert property (@(posedge clk) disable iff (rst)
    sr_q |-> (bank_open == '0));

  assert_sr_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (sr_q && !cke) |=> (sr_q && $stable(bank_open) && cmd_o == CMD_NOP));

  assert_ref_busy_err_R6: assert property (@(posedge clk) disable iff (rst)
    (!sr_q && dec == CMD_REF && (|bank_open)) |=> (err_o && !sr_q && $stable(bank_open)));

  assert_access_idle_err_R5: assert property (@(posedge clk) disable iff (rst)
    (!sr_q && (dec == CMD_RD || dec == CMD_WR) && !bank_open[ba]) |=> (err_o && $stable(bank_open)));
endmodule

// File: tb/dram_cmd_tracker_tb.sv
module dram_cmd_tracker_tb_top;
  localparam int NB = 4;
  localparam int RW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [RW-1:0] addr = '0;
  logic [3:0] cmd_o;
  logic [1:0] cmd_bank_o;
  logic err_o, sr_o, burst_ilv_o;
  logic [NB-1:0] bank_open_o;
  logic [NB*RW-1:0] open_row_o;
  logic [2:0] burst_len_o, cas_lat_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic          m_open [NB];
  logic [RW-1:0] m_row  [NB];
  logic          m_sr;
  logic [2:0]    m_bl, m_cl;
  logic          m_ilv;
  logic [3:0]    e_cmd;
  logic          e_err;
  logic [1:0]    e_bank;

  always #5 clk = ~clk;

  dram_cmd_tracker dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
    .err_o(err_o), .sr_o(sr_o), .bank_open_o(bank_open_o), .open_row_o(open_row_o),
    .burst_len_o(burst_len_o), .burst_ilv_o(burst_ilv_o), .cas_lat_o(cas_lat_o)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input logic c, input logic [2:0] s);
    if (c) return 4'd0;
    case (s)
      3'b011: return 4'd1;
      3'b101: return 4'd2;
      3'b100: return 4'd3;
      3'b010: return 4'd4;
      3'b001: return 4'd5;
      3'b110: return 4'd6;
      3'b000: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  task automatic check_all(input string req);
    cmp(req, "cmd", int'(cmd_o), int'(e_cmd));
    cmp(req, "err", int'(err_o), int'(e_err));
    cmp(req, "sr", int'(sr_o), int'(m_sr));
    cmp(req, "bank", int'(cmd_bank_o), int'(e_bank));
    for (int b = 0; b < NB; b++) begin
      cmp(req, "open", int'(bank_open_o[b]), int'(m_open[b]));
      cmp(req, "row", int'(open_row_o[b*RW +: RW]), int'(m_row[b]));
    end
    cmp(req, "burst_len", int'(burst_len_o), int'(m_bl));
    cmp(req, "burst_ilv", int'(burst_ilv_o), int'(m_ilv));
    cmp(req, "cas_lat", int'(cas_lat_o), int'(m_cl));
  endtask

  // one command: drive at falling edge, result checked after the next rising edge
  task automatic step(input logic c, input logic [2:0] s, input logic [1:0] b,
                      input logic [RW-1:0] a, input logic k, input string req);
    logic [3:0] d;
    logic busy;
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = s; ba = b; addr = a; cke = k;
    d = code_of(c, s);
    busy = 1'b0;
    for (int i = 0; i < NB; i++) busy |= m_open[i];
    e_err = 1'b0; e_bank = b;
    if (m_sr) begin
      e_cmd = k ? 4'd9 : 4'd0;
      if (k) m_sr = 1'b0;
    end else begin
      e_cmd = d;
      case (d)
        4'd1: if (m_open[b]) e_err = 1'b1; else begin m_open[b] = 1'b1; m_row[b] = a; end
        4'd2, 4'd3: if (!m_open[b]) e_err = 1'b1;
        4'd4: for (int i = 0; i < NB; i++)
                if (a[10] || i == int'(b)) begin m_open[i] = 1'b0; m_row[i] = '0; end
        4'd5: if (busy) e_err = 1'b1; else if (!k) begin m_sr = 1'b1; e_cmd = 4'd8; end
        4'd7: if (b == 2'd0) begin m_bl = a[2:0]; m_ilv = a[3]; m_cl = a[6:4]; end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    check_all(req);
  endtask

  localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100, S_PRE = 3'b010,
                         S_REF = 3'b001, S_BST = 3'b110, S_MRS = 3'b000, S_NOP = 3'b111;

  initial begin
    repeat (3000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
    m_sr = 1'b0; m_bl = '0; m_cl = '0; m_ilv = 1'b0;
    e_cmd = 4'd0; e_err = 1'b0; e_bank = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_all("R9");

    // R1: every strobe pattern with select low and high
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 8; p++)
        step(c[0], p[2:0], 2'(p), RW'(p * 37 + 5), 1'b1, "R1");
    step(1'b0, S_PRE, 2'd0, 13'h0400, 1'b1, "R4");

    // R2: open every bank with a distinct row (interleaved with reads)
    for (int b = 0; b < NB; b++) begin
      step(1'b0, S_ACT, 2'(b), RW'(b * 1234 + 7), 1'b1, "R2");
      if (b > 0) step(1'b0, S_RD, 2'(b - 1), 13'd0, 1'b1, "R3");
    end
    for (int b = 0; b < NB; b++) begin
      step(1'b0, S_WR, 2'(b), 13'd3, 1'b1, "R3");
      step(1'b0, S_ACT, 2'(b), 13'h1fff, 1'b1, "R5");
    end
    step(1'b0, S_BST, 2'd1, 13'd0, 1'b1, "R10");
    step(1'b0, S_NOP, 2'd2, 13'd0, 1'b1, "R10");
    step(1'b0, S_REF, 2'd0, 13'd0, 1'b1, "R6");
    step(1'b0, S_REF, 2'd0, 13'd0, 1'b0, "R6");
    step(1'b0, S_PRE, 2'd1, 13'd0, 1'b1, "R4");
    step(1'b0, S_PRE, 2'd1, 13'd0, 1'b1, "R4");
    step(1'b0, S_RD, 2'd1, 13'd0, 1'b1, "R5");
    step(1'b0, S_WR, 2'd1, 13'd0, 1'b1, "R5");
    step(1'b0, S_REF, 2'd0, 13'd0, 1'b1, "R6");
    step(1'b0, S_PRE, 2'd3, 13'h0400, 1'b1, "R4");
    step(1'b0, S_REF, 2'd0, 13'd0, 1'b1, "R6");

    // R8: mode loads, standard and extended
    step(1'b0, S_MRS, 2'd0, 13'b0000_0101_1010, 1'b1, "R8");
    step(1'b0, S_MRS, 2'd1, 13'b0000_0010_0111, 1'b1, "R8");
    step(1'b0, S_MRS, 2'd0, 13'b0000_0011_0011, 1'b1, "R8");

    // R7: self-refresh entry, ignored commands, exit
    step(1'b0, S_REF, 2'd0, 13'd0, 1'b0, "R7");
    step(1'b0, S_ACT, 2'd2, 13'd99, 1'b0, "R7");
    step(1'b0, S_MRS, 2'd0, 13'h7f, 1'b0, "R7");
    step(1'b0, S_RD, 2'd1, 13'd0, 1'b0, "R7");
    step(1'b1, S_NOP, 2'd0, 13'd0, 1'b1, "R7");
    step(1'b0, S_ACT, 2'd2, 13'd99, 1'b1, "R2");
    step(1'b0, S_REF, 2'd0, 13'd0, 1'b0, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule